// File: doc/BRIEF.md
# External Interrupt Request Control Register

This block is the per-pin control register for one external interrupt source. It holds the settings that software chooses for the source: a three-bit priority, an active-polarity choice and an edge-or-level sensing choice. It also holds the pending-request flag that the hardware sets when the pin shows the selected event. The pin is first passed through a two-stage synchronizer. A detector then watches the synchronized value for the chosen edge or the chosen level.

A downstream priority arbiter sees a request-valid strobe and the three-bit priority. When the arbiter takes the request, it pulses an acknowledge that clears the flag. Software reads and writes the whole byte through a plain write-enable, write-data and read-data interface. Software may clear the pending flag but can never raise it. A priority of zero keeps the source silent even when its flag is set.

Top module: `xirq_ctrl`

## Requirements
- R1: After synchronous reset, the read byte is 0x00 and request-valid is low.
- R2: The read byte is laid out as follows: bit 5 is sense (0 = edge, 1 = level), bit 4 is polarity (1 = rising/high, 0 = falling/low), bit 3 is the pending flag and bits 2:0 are the priority. A write loads bits 5, 4 and 2:0 from the write data, and they read back at the next clock.
- R3: Bits 7:6 read as 0 whatever was written to them.
- R4: A write with bit 3 = 0 clears the pending flag. A write with bit 3 = 1 leaves the flag as it was and never sets it.
- R5: In edge mode with polarity 1, a low-to-high pin transition sets the flag, and the flag stays set after the pin returns low.
- R6: In edge mode with polarity 0, a high-to-low transition sets the flag and a low-to-high transition does not.
- R7: In level mode, the flag is set on every clock while the synchronized pin is at the active level, so it comes back after a clear if the pin is still active. It stays clear once the pin is inactive.
- R8: Request-valid is high exactly when the flag is 1 and the priority is nonzero, and the priority output equals bits 2:0.
- R9: A one-cycle acknowledge pulse clears the flag when no hardware set occurs in that cycle.
- R10: When a hardware set and a clear (acknowledge or a write with bit 3 = 0) fall in the same cycle, the flag ends up set.
- R11: A pin change reaches the flag at the third rising clock edge after the change, and not before, because of the two synchronizer stages and the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte |
| ack_i | input | 1 | Acknowledge from the arbiter; clears the flag |
| req_valid_o | output | 1 | Pending request with nonzero priority |
| req_prio_o | output | 3 | Priority of the request |

## Verification
A hardware set of the pending flag can fall in the same cycle as a clear. The clear comes either from the arbiter acknowledge or from a software write of 0 to the flag. The bench provokes both cases in level mode while the pin is held active. It also times an acknowledge pulse to land exactly on the clock edge where a fresh rising edge reaches the flag, counting the two synchronizer stages. It then requires the flag to read 1 afterwards, and it confirms that a later acknowledge on its own does clear the flag.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int PRIO_W    = 3;
    localparam int DATA_W    = 8;
    localparam int FLAG_BIT  = 3;
    localparam int POL_BIT   = 4;
    localparam int SENSE_BIT = 5;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        sense_e              sense;
        logic                act_high;
        logic                flag;
        logic [PRIO_W-1:0]   prio;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_rd(input ctrl_t c);
        logic [DATA_W-1:0] r;
        r                  = '0;
        r[PRIO_W-1:0]      = c.prio;
        r[FLAG_BIT]        = c.flag;
        r[POL_BIT]         = c.act_high;
        r[SENSE_BIT]       = c.sense;
        return r;
    endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   s_i,
    input  logic   act_high,
    input  sense_e sense,
    output logic   hit_o
);
    logic prev;
    logic rise, fall, level_on;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= s_i;
    end

    always_comb begin
        rise     = s_i & ~prev;
        fall     = ~s_i & prev;
        level_on = act_high ? s_i : ~s_i;
        if (sense == SENSE_LEVEL) hit_o = level_on;
        else                      hit_o = act_high ? rise : fall;
    end

    // R6
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (sense == SENSE_EDGE && !act_high && hit_o) |-> (prev && !s_i));
endmodule

// File: rtl/xirq_core.sv
module xirq_core
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_i,
    input  logic              hit_i,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl;
    logic  sw_clr;

    assign sw_clr = wr_en & ~wr_data[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_en) begin
                ctrl.prio     <= wr_data[PRIO_W-1:0];
                ctrl.act_high <= wr_data[POL_BIT];
                ctrl.sense    <= sense_e'(wr_data[SENSE_BIT]);
            end
            if (hit_i)                ctrl.flag <= 1'b1;
            else if (ack_i || sw_clr) ctrl.flag <= 1'b0;
        end
    end

    assign ctrl_o = ctrl;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl.prio == '0 && !ctrl.flag));
    // R4
    no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.flag && !hit_i) |=> !ctrl.flag);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !hit_i) |=> !ctrl.flag);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> ctrl.flag);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              ack_i,
    output logic              req_valid_o,
    output logic [2:0]        req_prio_o
);
    logic  pin_s;
    logic  hit;
    ctrl_t ctrl;

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    xirq_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .s_i      (pin_s),
        .act_high (ctrl.act_high),
        .sense    (ctrl.sense),
        .hit_o    (hit)
    );

    xirq_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ack_i   (ack_i),
        .hit_i   (hit),
        .ctrl_o  (ctrl)
    );

    assign rd_data     = pack_rd(ctrl);
    assign req_prio_o  = ctrl.prio;
    assign req_valid_o = ctrl.flag & (ctrl.prio != '0);

    // R8
    zero_prio_silent_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (rd_data[3] && rd_data[2:0] != 3'd0));
endmodule

// File: tb/tb_xirq_ctrl.sv
`timescale 1ns/1ps
module tb_xirq_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       pin_i;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       ack_i;
    logic       req_valid_o;
    logic [2:0] req_prio_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xirq_ctrl dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ack_i(ack_i), .req_valid_o(req_valid_o),
        .req_prio_o(req_prio_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 valid", {7'd0, req_valid_o}, 8'h00);
    endtask

    task automatic t_fields();
        reg_write(8'hFF);
        chk("R2/R3/R4 fields, no sw set", rd_data, 8'h37);
        reg_write(8'h05);
        chk("R2 readback", rd_data, 8'h05);
        chk("R8 prio out", {5'd0, req_prio_o}, 8'h05);
        chk("R8 valid low w/o flag", {7'd0, req_valid_o}, 8'h00);
    endtask

    task automatic t_edge_rise();
        reg_write(8'h14);
        pin_i = 1'b1;
        wait_n(2);
        chk("R11 not before 3rd edge", {7'd0, rd_data[3]}, 8'h00);
        wait_n(1);
        chk("R11/R5 flag set", {7'd0, rd_data[3]}, 8'h01);
        chk("R8 valid", {7'd0, req_valid_o}, 8'h01);
        chk("R8 prio", {5'd0, req_prio_o}, 8'h04);
        pin_i = 1'b0;
        wait_n(4);
        chk("R5 flag held", {7'd0, rd_data[3]}, 8'h01);
        reg_write(8'h14);
        chk("R4 sw clear", rd_data, 8'h14);
        reg_write(8'h1C);
        chk("R4 write 1 no set", rd_data, 8'h14);
    endtask

    task automatic t_edge_fall();
        reg_write(8'h02);
        pin_i = 1'b1;
        wait_n(4);
        chk("R6 rise ignored", {7'd0, rd_data[3]}, 8'h00);
        pin_i = 1'b0;
        wait_n(4);
        chk("R6 fall sets", {7'd0, rd_data[3]}, 8'h01);
        pulse_ack();
        chk("R9 ack clears", {7'd0, rd_data[3]}, 8'h00);
    endtask

    task automatic t_level();
        reg_write(8'h33);
        wait_n(4);
        chk("R7 inactive no set", {7'd0, rd_data[3]}, 8'h00);
        pin_i = 1'b1;
        wait_n(4);
        chk("R7 active sets", {7'd0, rd_data[3]}, 8'h01);
        pulse_ack();
        chk("R10/R7 ack vs level set", {7'd0, rd_data[3]}, 8'h01);
        reg_write(8'h33);
        chk("R10 sw clear vs level set", rd_data, 8'h3B);
        pin_i = 1'b0;
        wait_n(4);
        pulse_ack();
        chk("R7 clear sticks when inactive", {7'd0, rd_data[3]}, 8'h00);
        wait_n(4);
        chk("R7 stays clear", {7'd0, rd_data[3]}, 8'h00);
    endtask

    task automatic t_prio0();
        reg_write(8'h30);
        pin_i = 1'b1;
        wait_n(4);
        chk("R8 flag with prio 0", {7'd0, rd_data[3]}, 8'h01);
        chk("R8 prio 0 silences", {7'd0, req_valid_o}, 8'h00);
        pin_i = 1'b0;
        wait_n(4);
        reg_write(8'h30);
    endtask

    task automatic t_collide_edge();
        reg_write(8'h11);
        wait_n(4);
        pin_i = 1'b1;
        wait_n(4);
        chk("R5 first edge", {7'd0, rd_data[3]}, 8'h01);
        pin_i = 1'b0;
        wait_n(4);
        pin_i = 1'b1;
        wait_n(2);
        pulse_ack();
        chk("R10 edge set beats ack", {7'd0, rd_data[3]}, 8'h01);
        pulse_ack();
        chk("R9 later ack clears", {7'd0, rd_data[3]}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; pin_i = 1'b0; wr_en = 1'b0; wr_data = 8'h00; ack_i = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_fields();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_prio0();
        t_collide_edge();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule